// File: doc/BRIEF.md
# Receive Eye-Scan Calibration Controller

This controller chooses the capture setting for a source-synchronous double-data-rate receive link. The data comes from a converter that can send a known pseudo-random test sequence instead of its samples. After every reset, the controller starts by itself. It asks the converter for the test sequence. It then tries every combination of converter output-clock polarity and receive delay tap. For each trial it waits for the delay line to settle and takes one verdict from an external pattern checker. Each verdict goes into a pass/fail vector.

When the sweep is over, the controller scans the vector for the longest run of passing taps. Runs are searched inside each polarity and never join across the polarity change. The controller selects the middle tap of that run. It writes the chosen polarity to the converter, loads the chosen tap, and returns the converter to normal sampling. Only after that does it report completion. A start pulse repeats the whole procedure on demand.

Converter commands go out over a request/acknowledge handshake to a separate serial register-write engine. The delay line receives a tap value with a one-cycle load strobe.

Top module: `eye_cal_ctrl`

## Requirements
- R1: Calibration begins on its own when reset is released, and `done` stays low until the procedure ends. While `done` is high, a one-cycle `start` pulse clears `done` and `error` on the next cycle and begins a new calibration. Command codes on `ser_cmd`: 0 = enter test-pattern mode, 1 = return to normal mode, 2 = normal clock polarity, 3 = inverted clock polarity. The first command of every calibration is code 0.
- R2: The sweep proceeds as follows. Command 2, then tap loads 0,1,…,31 in rising order. Then command 3, then tap loads 0,…,31 again. This gives 64 trials; trial index = polarity×32 + tap.
- R3: The checker is ignored from the tap-load cycle through the next `settle_cycles`+1 cycles. The verdict is taken from the first cycle after that in which `chk_valid` is high.
- R4: If no valid verdict arrives within `verdict_limit`+1 cycles of the settle period ending, the trial is recorded as a fail.
- R5: The selected run is the longest run of consecutive passing taps within one polarity. A run ending at tap 31 of normal polarity does not continue into tap 0 of inverted polarity. `best_len` reports its length.
- R6: When two runs have equal length, the one earlier in trial order wins. The selected tap is run start + (length−1)/2, rounded down.
- R7: After the sweep, the controller sends the chosen polarity command (2 or 3). It then loads the chosen tap, then sends command 1. Only after command 1 is acknowledged does `done` rise.
- R8: If no trial passes, the controller does the following. It sets `error` and keeps it set until the next start. It selects normal polarity and tap 0 with `best_len` = 0. It still sends command 2, loads tap 0, and sends command 1.
- R9: `ser_req` stays high with `ser_cmd` unchanged until a cycle in which `ser_ack` is high. Tap loads and serial requests never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Re-run request, honoured while `done` is high |
| settle_cycles | input | 10 | Settle wait after each tap load |
| verdict_limit | input | 10 | Verdict wait limit before a trial counts as failed |
| tap_load | output | 1 | One-cycle strobe loading `tap_value` into the delay line |
| tap_value | output | 5 | Delay tap to load |
| ser_req | output | 1 | Serial command request |
| ser_cmd | output | 2 | Command code (see R1) |
| ser_ack | input | 1 | Serial engine accepted the command |
| chk_valid | input | 1 | Checker verdict strobe |
| chk_pass | input | 1 | Checker verdict: test sequence received correctly |
| done | output | 1 | Calibration complete |
| error | output | 1 | No passing trial found |
| sel_pol | output | 1 | Chosen polarity (1 = inverted) |
| sel_tap | output | 5 | Chosen tap |
| best_len | output | 6 | Length of the chosen passing run |

## Verification
Five pass maps are swept. The first has two runs of different lengths in each polarity, so it shows that the longer run wins regardless of polarity. The second has equal-length runs on either side of the polarity boundary, which separates first-wins from last-wins and shows whether runs merge across the change. An all-fail map exercises the error path. An all-pass map gives a full-width run with even length, which tests the round-down midpoint. One map has a trial whose checker never answers, and the passing run must split at that trial. Throughout the sweep the checker returns the inverted verdict during the settle window. Any early sampling therefore moves the chosen tap.

// File: rtl/eyecal_pkg.sv
package eyecal_pkg;

  typedef enum logic [1:0] {
    CMD_PAT_ON  = 2'd0,
    CMD_PAT_OFF = 2'd1,
    CMD_POL_NRM = 2'd2,
    CMD_POL_INV = 2'd3
  } ser_cmd_e;

  typedef enum logic [3:0] {
    ST_PAT,
    ST_POL,
    ST_LOAD,
    ST_SETTLE,
    ST_WAIT,
    ST_SCAN_GO,
    ST_SCAN,
    ST_APOL,
    ST_ATAP,
    ST_NORM,
    ST_DONE
  } cal_state_e;

endpackage

// File: rtl/eyecal_timer.sv
module eyecal_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    if (clr)                 cnt_n = '0;
    else if (cnt != CNT_MAX) cnt_n = cnt + 1'b1;
    else                     cnt_n = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

endmodule

// File: rtl/eyecal_run_search.sv
module eyecal_run_search #(
  parameter int TAPS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [2*TAPS-1:0]          results,
  output logic                       fin,
  output logic [$clog2(TAPS+1)-1:0]  best_len,
  output logic                       best_pol,
  output logic [$clog2(TAPS)-1:0]    best_tap
);

  localparam int NTRIAL = 2 * TAPS;
  localparam int IDX_W  = $clog2(NTRIAL);
  localparam int TAP_W  = $clog2(TAPS);
  localparam int LEN_W  = $clog2(TAPS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NTRIAL - 1);

  logic             busy_q, busy_n, fin_q, fin_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [LEN_W-1:0] cur_len_q, cur_len_n, best_len_q, best_len_n;
  logic [TAP_W-1:0] cur_start_q, cur_start_n, best_start_q, best_start_n;
  logic             best_pol_q, best_pol_n;

  logic [TAP_W-1:0] tap_i;
  logic             pol_i;
  logic [LEN_W-1:0] base_len, ext_len, half_len;
  logic [TAP_W-1:0] ext_start;

  assign tap_i     = idx_q[TAP_W-1:0];
  assign pol_i     = idx_q[IDX_W-1];
  // a run never carries over the first tap of a polarity
  assign base_len  = (tap_i == '0) ? '0 : cur_len_q;
  assign ext_len   = base_len + 1'b1;
  assign ext_start = (base_len == '0) ? tap_i : cur_start_q;

  always_comb begin
    busy_n       = busy_q;
    idx_n        = idx_q;
    cur_len_n    = cur_len_q;
    cur_start_n  = cur_start_q;
    best_len_n   = best_len_q;
    best_start_n = best_start_q;
    best_pol_n   = best_pol_q;
    fin_n        = 1'b0;
    if (go) begin
      busy_n       = 1'b1;
      idx_n        = '0;
      cur_len_n    = '0;
      cur_start_n  = '0;
      best_len_n   = '0;
      best_start_n = '0;
      best_pol_n   = 1'b0;
    end else if (busy_q) begin
      if (results[idx_q]) begin
        cur_len_n   = ext_len;
        cur_start_n = ext_start;
        if (ext_len > best_len_q) begin  // strict: earlier run keeps ties
          best_len_n   = ext_len;
          best_start_n = ext_start;
          best_pol_n   = pol_i;
        end
      end else begin
        cur_len_n = '0;
      end
      if (idx_q == IDX_LAST) begin
        busy_n = 1'b0;
        fin_n  = 1'b1;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      fin_q        <= 1'b0;
      idx_q        <= '0;
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
      best_pol_q   <= 1'b0;
    end else begin
      busy_q       <= busy_n;
      fin_q        <= fin_n;
      idx_q        <= idx_n;
      cur_len_q    <= cur_len_n;
      cur_start_q  <= cur_start_n;
      best_len_q   <= best_len_n;
      best_start_q <= best_start_n;
      best_pol_q   <= best_pol_n;
    end
  end

  assign half_len = (best_len_q - 1'b1) >> 1;
  assign fin      = fin_q;
  assign best_len = best_len_q;
  assign best_pol = best_pol_q;
  assign best_tap = (best_len_q == '0) ? '0 : best_start_q + half_len[TAP_W-1:0];

  // R5: a run can never be longer than one polarity's tap range
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    best_len_q <= LEN_W'(TAPS));

  // R6: the best length never shrinks during a scan
  a_r6_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !go |=> best_len_q >= $past(best_len_q));

endmodule

// File: rtl/eye_cal_ctrl.sv
module eye_cal_ctrl #(
  parameter int TAPS  = 32,
  parameter int CNT_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CNT_W-1:0]           settle_cycles,
  input  logic [CNT_W-1:0]           verdict_limit,
  output logic                       tap_load,
  output logic [$clog2(TAPS)-1:0]    tap_value,
  output logic                       ser_req,
  output logic [1:0]                 ser_cmd,
  input  logic                       ser_ack,
  input  logic                       chk_valid,
  input  logic                       chk_pass,
  output logic                       done,
  output logic                       error,
  output logic                       sel_pol,
  output logic [$clog2(TAPS)-1:0]    sel_tap,
  output logic [$clog2(TAPS+1)-1:0]  best_len
);
  import eyecal_pkg::*;

  localparam int NTRIAL = 2 * TAPS;
  localparam int TAP_W  = $clog2(TAPS);
  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAPS - 1);

  cal_state_e        state_q, state_n;
  logic [TAP_W-1:0]  tap_q, tap_n;
  logic              pol_q, pol_n;
  logic [NTRIAL-1:0] res_q, res_n;
  logic              done_q, done_n, err_q, err_n;
  ser_cmd_e          cmd;

  logic              tmr_clr, settle_end, wait_expired, scan_go, scan_fin;
  logic [CNT_W-1:0]  tmr_cnt;

  assign settle_end   = (tmr_cnt == settle_cycles);
  assign wait_expired = (tmr_cnt == verdict_limit);
  assign tmr_clr      = !((state_q == ST_SETTLE && !settle_end) || state_q == ST_WAIT);
  assign scan_go      = (state_q == ST_SCAN_GO);

  eyecal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (tmr_cnt)
  );

  eyecal_run_search #(.TAPS(TAPS)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (scan_go),
    .results  (res_q),
    .fin      (scan_fin),
    .best_len (best_len),
    .best_pol (sel_pol),
    .best_tap (sel_tap)
  );

  always_comb begin
    state_n = state_q;
    tap_n   = tap_q;
    pol_n   = pol_q;
    res_n   = res_q;
    done_n  = done_q;
    err_n   = err_q;
    unique case (state_q)
      ST_PAT:     if (ser_ack) state_n = ST_POL;
      ST_POL:     if (ser_ack) state_n = ST_LOAD;
      ST_LOAD:    state_n = ST_SETTLE;
      ST_SETTLE:  if (settle_end) state_n = ST_WAIT;
      ST_WAIT: begin
        if (chk_valid || wait_expired) begin
          res_n[{pol_q, tap_q}] = chk_valid && chk_pass;
          if (tap_q == TAP_LAST) begin
            tap_n = '0;
            if (pol_q) begin
              state_n = ST_SCAN_GO;
            end else begin
              pol_n   = 1'b1;
              state_n = ST_POL;
            end
          end else begin
            tap_n   = tap_q + 1'b1;
            state_n = ST_LOAD;
          end
        end
      end
      ST_SCAN_GO: state_n = ST_SCAN;
      ST_SCAN: begin
        if (scan_fin) begin
          err_n   = (best_len == '0);
          state_n = ST_APOL;
        end
      end
      ST_APOL:    if (ser_ack) state_n = ST_ATAP;
      ST_ATAP:    state_n = ST_NORM;
      ST_NORM: begin
        if (ser_ack) begin
          done_n  = 1'b1;
          state_n = ST_DONE;
        end
      end
      ST_DONE: begin
        if (start) begin
          done_n  = 1'b0;
          err_n   = 1'b0;
          tap_n   = '0;
          pol_n   = 1'b0;
          state_n = ST_PAT;
        end
      end
      default:    state_n = ST_PAT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAT;
      tap_q   <= '0;
      pol_q   <= 1'b0;
      res_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      tap_q   <= tap_n;
      pol_q   <= pol_n;
      res_q   <= res_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PAT:  cmd = CMD_PAT_ON;
      ST_POL:  cmd = pol_q ? CMD_POL_INV : CMD_POL_NRM;
      ST_APOL: cmd = sel_pol ? CMD_POL_INV : CMD_POL_NRM;
      default: cmd = CMD_PAT_OFF;
    endcase
  end

  assign ser_req   = (state_q == ST_PAT) || (state_q == ST_POL) ||
                     (state_q == ST_APOL) || (state_q == ST_NORM);
  assign ser_cmd   = cmd;
  assign tap_load  = (state_q == ST_LOAD) || (state_q == ST_ATAP);
  assign tap_value = (state_q == ST_ATAP) ? sel_tap : tap_q;
  assign done      = done_q;
  assign error     = err_q;

  // R9: request held with a stable command until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req && !ser_ack |=> ser_req && $stable(ser_cmd));

  // R9: tap loads and serial requests are exclusive
  a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_req && tap_load));

  // R7: once complete, the block issues no further actions
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ser_req && !tap_load);

  // R1: completion holds until a start request
  a_r1_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R8: the error flag only accompanies an empty selection
  a_r8_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> best_len == '0 && sel_tap == '0 && !sel_pol);

endmodule

// File: tb/eye_cal_ctrl_tb.sv
module eye_cal_ctrl_tb;

  localparam int SETTLE = 3;
  localparam int LIMIT  = 5;

  logic       clk = 1'b0;
  logic       rst_n, start;
  logic [9:0] settle_cycles, verdict_limit;
  logic       tap_load, ser_req, ser_ack, chk_valid, chk_pass;
  logic [4:0] tap_value, sel_tap;
  logic [1:0] ser_cmd;
  logic       done, error, sel_pol;
  logic [5:0] best_len;

  always #5 clk = ~clk;

  eye_cal_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .settle_cycles(settle_cycles), .verdict_limit(verdict_limit),
    .tap_load(tap_load), .tap_value(tap_value),
    .ser_req(ser_req), .ser_cmd(ser_cmd), .ser_ack(ser_ack),
    .chk_valid(chk_valid), .chk_pass(chk_pass),
    .done(done), .error(error), .sel_pol(sel_pol),
    .sel_tap(sel_tap), .best_len(best_len)
  );

  int tests = 0;
  int fails = 0;
  bit pat[64];
  bit silent[64];
  int exp_q[$];
  int exp_pol, exp_tap, exp_len;
  bit running = 0;
  int ack_cnt = 0;
  int k = 0;
  int curpol = 0;
  int curtap = 0;
  int cyc = 0;

  task automatic check(string req, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_map();
    for (int i = 0; i < 64; i++) begin
      pat[i] = 1'b0;
      silent[i] = 1'b0;
    end
  endtask

  task automatic set_run(int p, int lo, int hi);
    for (int t = lo; t <= hi; t++) pat[p*32 + t] = 1'b1;
  endtask

  // reference: expected selection and event trace from the pass map
  task automatic build_expect();
    int best, run;
    best = 0; exp_pol = 0; exp_tap = 0;
    for (int p = 0; p < 2; p++) begin
      run = 0;
      for (int t = 0; t < 32; t++) begin
        if (pat[p*32+t] && !silent[p*32+t]) begin
          run++;
          if (run > best) begin
            best = run; exp_pol = p; exp_tap = t - run + 1;
          end
        end else run = 0;
      end
    end
    exp_len = best;
    if (best > 0) exp_tap = exp_tap + (best - 1) / 2;
    exp_q.delete();
    exp_q.push_back(100);
    for (int p = 0; p < 2; p++) begin
      exp_q.push_back(102 + p);
      for (int t = 0; t < 32; t++) exp_q.push_back(t);
    end
    exp_q.push_back(102 + exp_pol);
    exp_q.push_back(exp_tap);
    exp_q.push_back(101);
  endtask

  task automatic log_event(int ev);
    int e;
    tests++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R2/R7 unexpected event: actual %0d expected none", ev);
    end else begin
      e = exp_q.pop_front();
      if (e != ev) begin
        fails++;
        $display("FAIL R2/R7 event order: actual %0d expected %0d", ev, e);
      end
    end
  endtask

  // environment: serial engine, delay line observer, pattern checker
  always @(negedge clk) begin
    if (!rst_n) begin
      ser_ack = 1'b0; ack_cnt = 0; k = 0;
    end else begin
      if (ser_ack) begin
        ser_ack = 1'b0; ack_cnt = 0;
      end else if (ser_req) begin
        ack_cnt++;
        if (ack_cnt == 2) begin
          ser_ack = 1'b1;
          ack_cnt = 0;
          log_event(100 + int'(ser_cmd));
          if (ser_cmd == 2'd2) curpol = 0;
          if (ser_cmd == 2'd3) curpol = 1;
        end
      end else ack_cnt = 0;
      if (tap_load) begin
        log_event(int'(tap_value));
        k = 0;
        curtap = int'(tap_value);
      end else k++;
      // R3: inverted verdict during the settle window exposes early sampling
      chk_valid = !silent[curpol*32 + curtap];
      chk_pass  = (k >= SETTLE + 2) ? pat[curpol*32 + curtap] : !pat[curpol*32 + curtap];
      // R7: per-clock comparison - done must stay low while events are pending
      if (running && done && exp_q.size() != 0) begin
        tests++; fails++;
        $display("FAIL R7 done early: actual 1 expected 0 (%0d events pending)", exp_q.size());
        running = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_done(string tag);
    while (!done) @(negedge clk);
    running = 0;
    check({tag, " R7 trace fully consumed"}, exp_q.size(), 0);
    check({tag, " R8 error"}, int'(error), (exp_len == 0) ? 1 : 0);
    check({tag, " R5 best_len"}, int'(best_len), exp_len);
    check({tag, " R5 sel_pol"}, int'(sel_pol), exp_pol);
    check({tag, " R6 sel_tap"}, int'(sel_tap), exp_tap);
  endtask

  task automatic restart(string tag);
    build_expect();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R1 done cleared by start"}, int'(done), 0);
    check({tag, " R1 error cleared by start"}, int'(error), 0);
    running = 1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ser_ack = 1'b0;
    chk_valid = 1'b0; chk_pass = 1'b0;
    settle_cycles = 10'(SETTLE); verdict_limit = 10'(LIMIT);

    // map A: longer run in inverted polarity (R5)
    clear_map();
    set_run(0, 3, 6);
    set_run(1, 10, 20);
    build_expect();
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset error", int'(error), 0);
    rst_n = 1'b1;
    running = 1;
    wait_done("mapA R3");

    // map B: equal runs across the polarity boundary (R5, R6)
    clear_map();
    set_run(0, 5, 7);
    set_run(0, 28, 31);
    set_run(1, 0, 3);
    restart("mapB");
    wait_done("mapB");

    // map C: nothing passes (R8)
    clear_map();
    restart("mapC");
    wait_done("mapC");

    // map D: silent checker splits a run (R4)
    clear_map();
    set_run(0, 0, 7);
    set_run(1, 1, 31);
    silent[32 + 12] = 1'b1;
    restart("mapD R4");
    wait_done("mapD R4");

    // map E: full-width even run, round-down midpoint (R6)
    clear_map();
    set_run(0, 0, 31);
    set_run(1, 0, 31);
    restart("mapE");
    wait_done("mapE");

    repeat (3) @(negedge clk);
    check("R7 idle after done", int'(ser_req) + int'(tap_load), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule